// File: doc/BRIEF.md
# Memory-Mapped Shift-and-Add Multiply Coprocessor

This block attaches a serial multiply engine to a simple CPU bus as a slave. The CPU sees four consecutive word addresses starting at a parameterised base. The first three hold the engine's operands and accumulator, and the CPU can load or read them. The fourth is a command and status slot. Writing it launches an operation, and reading it reports whether the engine is busy and which operation was last launched.

The engine runs a fixed number of steps equal to the data width. In multiply mode each step conditionally adds the multiplicand into the accumulator and shifts the accumulator and multiplier pair right by one. When it finishes, the pair holds the multiplier times the multiplicand plus the starting accumulator. Divide mode is a placeholder. It takes the same number of steps and leaves every register untouched. This lets software code for it now.

Software does not have to time the engine. A read of the multiplier or accumulator slot while the engine is busy raises a wait line. The CPU holds its read until that line drops, so straight-line code still gets the final result. Code that has useful work to do in the meantime can instead poll the status slot.

Top module: `mmio_mul_cop`

## Requirements
- R1: After reset, the multiplier, accumulator, multiplicand, busy flag and operation code are all zero, so every slot of the window reads zero.
- R2: While idle, a write to offset 0 (multiplier), 1 (accumulator) or 2 (multiplicand) loads that register, and a read of the same offset returns it.
- R3: A write to offset 3 while idle makes the busy flag go high from the next cycle for exactly W cycles. It latches wdata bit 0 as the operation code (0 = multiply, 1 = divide). All other data bits are ignored.
- R4: When a multiply completes, the accumulator (offset 1) holds the upper W bits and the multiplier (offset 0) holds the lower W bits of multiplier*multiplicand + accumulator, taken from the values present at the start.
- R5: A read of offset 3 returns the busy flag in bit 0 and the latched operation code in bit 1, with all other bits zero.
- R6: A read of offset 0 or 1 while busy asserts wait every cycle until busy drops. Rdata is meaningful only while wait is low, and it then returns the final result.
- R7: Reads of offset 2 or offset 3 never assert wait.
- R8: While busy, writes to offsets 0 to 2 are ignored. A write to offset 3 is also ignored: it does not restart the engine, extend the busy time or change the operation code.
- R9: A divide operation stays busy for W cycles and leaves the multiplier, accumulator and multiplicand unchanged.
- R10: An address outside the window gets no response. Rdata is zero and wait is low, and a write there changes no register.
- R11: Rdata is zero whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Word address |
| bus_wdata | input | W | Write data |
| bus_rd | input | 1 | Read strobe, held by the master until wait is low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | W | Read data, zero when not selected |
| bus_wait | output | 1 | Stall request for the current read |

## Verification
Two events can land on the same clock edge: a bus write to a register and a step of the running engine. The bench provokes this by writing the multiplier slot and re-writing the command slot while an operation is in flight. It judges the outcome from the result read afterwards, which must match the product of the operands captured at launch, and from the busy time, which must still be exactly W cycles. A second collision is a stalled accumulator read whose release coincides with the final step. The bench checks that wait lasts exactly W-1 sampled cycles and that the value returned is the completed sum. A cycle-level reference model compares wait and rdata on every clock.

// File: rtl/cop_pkg.sv
package cop_pkg;
   typedef enum logic {
      OP_MUL = 1'b0,
      OP_DIV = 1'b1
   } cop_op_e;

   localparam int unsigned SLOT_COUNT = 4;
   localparam int unsigned SLOT_MPLIER = 0;
   localparam int unsigned SLOT_ACCUM  = 1;
   localparam int unsigned SLOT_MCAND  = 2;
   localparam int unsigned SLOT_CMD    = 3;
endpackage

// File: rtl/cop_decode.sv
module cop_decode #(
   parameter int unsigned AW   = 8,
   parameter logic [AW-1:0] BASE = 8'h40
) (
   input  logic [AW-1:0] addr,
   input  logic          rd,
   input  logic          wr,
   output logic          hit,
   output logic [cop_pkg::SLOT_COUNT-1:0] rd_sel,
   output logic [cop_pkg::SLOT_COUNT-1:0] wr_sel
);
   localparam int unsigned OFS_W = $clog2(cop_pkg::SLOT_COUNT);

   if (BASE[OFS_W-1:0] != '0) begin : g_bad_base
      $error("cop_decode: BASE must be aligned to the window size");
   end
   if (AW <= OFS_W) begin : g_bad_aw
      $error("cop_decode: AW too small for the window");
   end

   logic [cop_pkg::SLOT_COUNT-1:0] sel;

   assign hit = (addr[AW-1:OFS_W] == BASE[AW-1:OFS_W]);

   for (genvar i = 0; i < cop_pkg::SLOT_COUNT; i++) begin : g_sel
      assign sel[i]    = hit && (addr[OFS_W-1:0] == OFS_W'(i));
      assign rd_sel[i] = sel[i] && rd;
      assign wr_sel[i] = sel[i] && wr;
   end
endmodule

// File: rtl/cop_engine.sv
module cop_engine
   import cop_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  cop_op_e      op_in,
   input  logic [2:0]   ld,
   input  logic [W-1:0] ld_data,
   output logic         run,
   output cop_op_e      op,
   output logic [W-1:0] mplier_q,
   output logic [W-1:0] accum_q,
   output logic [W-1:0] mcand_q
);
   localparam int unsigned CW = (W < 2) ? 1 : $clog2(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   if (W < 2) begin : g_bad_w
      $error("cop_engine: W must be at least 2");
   end

   logic [CW-1:0] cnt;
   logic [W:0]    sum;
   logic [W-1:0]  accum_n, mplier_n;

   // sequencer: W step cycles per launch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         cnt <= '0;
         op  <= OP_MUL;
      end else if (run) begin
         cnt <= cnt + 1'b1;
         if (cnt == LAST) run <= 1'b0;
      end else if (start) begin
         run <= 1'b1;
         cnt <= '0;
         op  <= op_in;
      end
   end

   // one shift-and-add step
   always_comb begin
      sum = {1'b0, accum_q} + {1'b0, mcand_q};
      if (mplier_q[0]) begin
         accum_n  = sum[W:1];
         mplier_n = {sum[0], mplier_q[W-1:1]};
      end else begin
         accum_n  = {1'b0, accum_q[W-1:1]};
         mplier_n = {accum_q[0], mplier_q[W-1:1]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mplier_q <= '0;
         accum_q  <= '0;
         mcand_q  <= '0;
      end else if (run) begin
         if (op == OP_MUL) begin
            mplier_q <= mplier_n;
            accum_q  <= accum_n;
         end
      end else begin
         if (ld[SLOT_MPLIER]) mplier_q <= ld_data;
         if (ld[SLOT_ACCUM])  accum_q  <= ld_data;
         if (ld[SLOT_MCAND])  mcand_q  <= ld_data;
      end
   end

   a_r3_start_sets_run: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !run) |=> run);
   a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (start && run) |=> $stable(op));
   a_r8_mcand_held: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> $stable(mcand_q));
   a_r9_div_holds_regs: assert property (@(posedge clk) disable iff (!rst_n)
      (run && op == OP_DIV) |=> ($stable(accum_q) && $stable(mplier_q)));
endmodule

// File: rtl/mmio_mul_cop.sv
module mmio_mul_cop
   import cop_pkg::*;
#(
   parameter int unsigned   W    = 16,
   parameter int unsigned   AW   = 8,
   parameter logic [AW-1:0] BASE = 8'h40
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic [W-1:0]  bus_wdata,
   input  logic          bus_rd,
   input  logic          bus_wr,
   output logic [W-1:0]  bus_rdata,
   output logic          bus_wait
);
   logic                  hit;
   logic [SLOT_COUNT-1:0] rd_sel, wr_sel;
   logic                  run;
   cop_op_e               op;
   logic [W-1:0]          mplier_q, accum_q, mcand_q;
   logic [W-1:0]          status_word;

   cop_decode #(.AW(AW), .BASE(BASE)) dec_i (
      .addr   (bus_addr),
      .rd     (bus_rd),
      .wr     (bus_wr),
      .hit    (hit),
      .rd_sel (rd_sel),
      .wr_sel (wr_sel)
   );

   cop_engine #(.W(W)) eng_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (wr_sel[SLOT_CMD]),
      .op_in    (cop_op_e'(bus_wdata[0])),
      .ld       (wr_sel[2:0]),
      .ld_data  (bus_wdata),
      .run      (run),
      .op       (op),
      .mplier_q (mplier_q),
      .accum_q  (accum_q),
      .mcand_q  (mcand_q)
   );

   assign status_word = {{(W-2){1'b0}}, op, run};

   always_comb begin
      bus_rdata = '0;
      unique case (1'b1)
         rd_sel[SLOT_MPLIER]: bus_rdata = mplier_q;
         rd_sel[SLOT_ACCUM]:  bus_rdata = accum_q;
         rd_sel[SLOT_MCAND]:  bus_rdata = mcand_q;
         rd_sel[SLOT_CMD]:    bus_rdata = status_word;
         default:             bus_rdata = '0;
      endcase
   end

   assign bus_wait = run && (rd_sel[SLOT_MPLIER] || rd_sel[SLOT_ACCUM]);

   a_r6_wait_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wait |-> run);
   a_r10_outside_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !hit) |-> (bus_rdata == '0 && !bus_wait));
   a_r11_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/mmio_mul_cop_tb.sv
module mmio_mul_cop_tb_top;
   localparam int unsigned   W          = 16;
   localparam int unsigned   AW         = 8;
   localparam logic [AW-1:0] BASE       = 8'h40;
   localparam time           CLK_PERIOD = 10ns;
   localparam int            WDOG_LIMIT = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [W-1:0]  bus_wdata = '0;
   logic          bus_rd = 1'b0;
   logic          bus_wr = 1'b0;
   logic [W-1:0]  bus_rdata;
   logic          bus_wait;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mmio_mul_cop #(.W(W), .AW(AW), .BASE(BASE)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_wait(bus_wait)
   );

   // behavioural reference model
   longint unsigned m_ier = 0, m_acc = 0, m_icand = 0, m_res = 0;
   bit m_run = 0, m_op = 0;
   int m_cnt = 0;

   function automatic bit in_win(logic [AW-1:0] a);
      return (a >= BASE) && (a < BASE + 4);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ier = 0; m_acc = 0; m_icand = 0; m_run = 0; m_op = 0; m_cnt = 0;
      end else if (m_run) begin
         m_cnt++;
         if (m_cnt == W) begin
            m_run = 0;
            if (!m_op) begin
               m_acc = (m_res >> W) & ((64'd1 << W) - 1);
               m_ier = m_res & ((64'd1 << W) - 1);
            end
         end
      end else if (bus_wr && in_win(bus_addr)) begin
         case (bus_addr - BASE)
            0: m_ier = bus_wdata;
            1: m_acc = bus_wdata;
            2: m_icand = bus_wdata;
            default: begin
               m_run = 1; m_cnt = 0; m_op = bus_wdata[0];
               m_res = m_ier * m_icand + m_acc;
            end
         endcase
      end
   end

   task automatic chk(string req, longint unsigned act, longint unsigned exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-cycle comparison of wait and rdata against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit ew;
         longint unsigned er;
         ew = bus_rd && in_win(bus_addr) && (bus_addr - BASE < 2) && m_run;
         er = 0;
         if (bus_rd && in_win(bus_addr))
            case (bus_addr - BASE)
               0: er = m_ier;
               1: er = m_acc;
               2: er = m_icand;
               default: er = {m_op, m_run};
            endcase
         chk("R6 R7 R10 per-cycle wait", bus_wait, ew);
         if (!ew) chk("R2 R5 R11 per-cycle rdata", bus_rdata, er);
      end
   end

   task automatic bus_write(int ofs, logic [W-1:0] d);
      @(posedge clk); #1;
      bus_addr = BASE + AW'(ofs); bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(int ofs, output logic [W-1:0] d, output int waits);
      waits = 0;
      @(posedge clk); #1;
      bus_addr = BASE + AW'(ofs); bus_rd = 1'b1;
      forever begin
         @(negedge clk);
         if (!bus_wait || waits > 4*W) break;
         waits++;
      end
      d = bus_rdata;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic wait_idle();
      logic [W-1:0] s;
      int w;
      for (int i = 0; i < 4*W; i++) begin
         bus_read(3, s, w);
         if (!s[0]) break;
      end
   endtask

   // poll status straight after a launch; returns number of busy cycles seen
   task automatic poll_busy(output int busy, output bit op_seen);
      busy = 0; op_seen = 0;
      bus_addr = BASE + 3; bus_rd = 1'b1;
      for (int i = 0; i < 4*W; i++) begin
         @(negedge clk);
         if (!bus_rdata[0]) break;
         busy++;
         op_seen = bus_rdata[1];
      end
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   initial begin
      repeat (WDOG_LIMIT) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] d;
      int w, busy;
      bit opb;
      longint unsigned r;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      for (int k = 0; k < 4; k++) begin
         bus_read(k, d, w);
         chk("R1 reset value", d, 0);
      end

      // R2 register access
      bus_write(0, 16'h1234); bus_write(1, 16'h0003); bus_write(2, 16'h00FF);
      bus_read(0, d, w); chk("R2 mplier readback", d, 16'h1234);
      bus_read(1, d, w); chk("R2 accum readback", d, 16'h0003);
      bus_read(2, d, w); chk("R2 mcand readback", d, 16'h00FF);

      // R3 busy duration and R5 status format
      r = 64'h1234 * 64'h00FF + 64'h3;
      bus_write(3, 16'hFFFE);
      poll_busy(busy, opb);
      chk("R3 busy cycles", busy, W);
      chk("R3 R5 op bit multiply", opb, 0);
      bus_read(1, d, w); chk("R4 accum high half", d, r >> W);
      bus_read(0, d, w); chk("R4 mplier low half", d, r & 16'hFFFF);
      bus_read(3, d, w); chk("R5 status idle", d, 0);

      // R6 stalled read of accum returns final value
      bus_write(0, 16'hFFFF); bus_write(1, 16'hFFFF); bus_write(2, 16'hFFFF);
      r = 64'hFFFF * 64'hFFFF + 64'hFFFF;
      bus_write(3, 16'h0000);
      bus_read(1, d, w);
      chk("R6 wait cycles", w, W - 1);
      chk("R6 R4 max accum", d, r >> W);
      bus_read(0, d, w); chk("R4 max mplier", d, r & 16'hFFFF);

      // R7 no wait on mcand/status; R8 ignored writes while busy
      bus_write(0, 16'h0005); bus_write(1, 16'h0000); bus_write(2, 16'h0007);
      bus_write(3, 16'h0000);
      bus_read(2, d, w);
      chk("R7 mcand no wait", w, 0);
      chk("R7 mcand value", d, 16'h0007);
      bus_read(3, d, w);
      chk("R7 status no wait", w, 0);
      chk("R5 status busy", d, 16'h0001);
      bus_write(0, 16'hAAAA);
      bus_write(2, 16'h5555);
      bus_write(3, 16'h0001);
      wait_idle();
      bus_read(0, d, w); chk("R8 mplier write ignored", d, 16'd35);
      bus_read(2, d, w); chk("R8 mcand write ignored", d, 16'h0007);
      bus_read(3, d, w); chk("R8 op unchanged", d, 16'h0000);

      // R8 restart attempt does not extend busy time
      bus_write(3, 16'h0000);
      @(posedge clk); #1;
      bus_addr = BASE + 3; bus_wdata = 16'h0001; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
      poll_busy(busy, opb);
      chk("R8 busy not extended", busy, W - 2);
      chk("R8 op stays multiply", opb, 0);

      // R9 divide stub
      bus_write(0, 16'h00C3); bus_write(1, 16'h0042); bus_write(2, 16'h0011);
      bus_write(3, 16'h0001);
      poll_busy(busy, opb);
      chk("R9 divide busy cycles", busy, W);
      chk("R9 R5 op bit divide", opb, 1);
      bus_read(0, d, w); chk("R9 mplier kept", d, 16'h00C3);
      bus_read(1, d, w); chk("R9 accum kept", d, 16'h0042);
      bus_read(2, d, w); chk("R9 mcand kept", d, 16'h0011);
      bus_read(3, d, w); chk("R5 op latched idle", d, 16'h0002);

      // R10 outside window
      @(posedge clk); #1;
      bus_addr = BASE + 4; bus_wdata = 16'hDEAD; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_addr = BASE - 1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
      bus_read(0, d, w); chk("R10 mplier untouched", d, 16'h00C3);
      bus_read(1, d, w); chk("R10 accum untouched", d, 16'h0042);
      bus_write(3, 16'h0000);
      @(posedge clk); #1;
      bus_addr = BASE + 5; bus_rd = 1'b1;
      @(negedge clk);
      chk("R10 outside rdata", bus_rdata, 0);
      chk("R10 outside no wait", bus_wait, 0);
      @(posedge clk); #1;
      bus_rd = 1'b0;
      @(negedge clk);
      chk("R11 no strobe rdata", bus_rdata, 0);
      wait_idle();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule